// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access mover. A start pulse loads a read pointer, a write pointer, a transfer count and a set of control fields. The channel then repeats a read on a memory-style read port followed by a write on a memory-style write port until the count runs out. Each transfer is one byte, one halfword or one word. The count is a number of transfers, not bytes.

Each pointer may step by the transfer size after every transfer, or stay fixed, as a peripheral data register does. One selected pointer can be confined to a power-of-two ring by freezing its upper address bits. The data can have its byte order reversed on the way through. An optional pacing input holds back each transfer until the attached peripheral asks for one. The channel reports busy, a one-cycle done pulse, and sticky read and write error flags that software clears.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset busy_o, done_o, rd_req_o, wr_req_o, err_rd_o, err_wr_o and err_any_o are all 0.
- R2: A start_i pulse sampled while the channel is idle, with cfg_enable_i = 1 and cfg_count_i != 0, loads the pointers, the count and the control fields, and busy_o is 1 from the next cycle. A start with cfg_enable_i = 0 or with cfg_count_i = 0 is ignored: busy_o stays 0 and no read is issued.
- R3: A sequence performs exactly cfg_count_i read/write pairs. After the last write is accepted, busy_o falls and done_o is 1 for exactly that one cycle.
- R4: cfg_size_i encodes 0 = byte, 1 = halfword, 2 = word, and 3 behaves as word. The code is presented on rd_size_o and wr_size_o. An incrementing pointer advances by 1, 2 or 4 bytes.
- R5: cfg_inc_rd_i and cfg_inc_wr_i each decide whether their pointer advances after a transfer. A pointer with its flag at 0 keeps its address for the whole sequence.
- R6: With cfg_ring_bits_i = N != 0, only the low N bits of the selected pointer change when it advances, so it wraps on a 2^N-byte boundary. cfg_ring_wr_i = 0 selects the read pointer and 1 selects the write pointer. N = 0 disables wrapping.
- R7: Write data is the read data's low 8, 16 or 32 bits, zero-extended to 32 bits. With cfg_bswap_i = 1 the two bytes of a halfword, or the four bytes of a word, are reversed. Byte transfers are never altered.
- R8: When cfg_paced_i = 1, every read is issued only after pace_req_i has been sampled high while the channel waits. A single-cycle request allows exactly one transfer.
- R9: Only one transfer is in flight. rd_req_o and wr_req_o are never high together. A request and its address stay steady until acknowledged. A new read starts only after the previous write was acknowledged.
- R10: An acknowledge with rd_err_i or wr_err_i high stops the channel (busy_o falls, no done_o) and latches err_rd_o or err_wr_o. err_any_o is the OR of the two flags.
- R11: A one-cycle clr_rd_err_i or clr_wr_err_i pulse clears the matching flag. A new error in the same cycle as the clear wins, and the flag stays set.
- R12: rd_addr_o and wr_addr_o always hold the addresses of the next transfer, and remain_o holds the number of transfers still to do. After an error the pointers still name the transfer that failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a sequence with the cfg_* values |
| cfg_enable_i | input | 1 | Channel enable for this start |
| cfg_rd_addr_i | input | AW | Initial read pointer |
| cfg_wr_addr_i | input | AW | Initial write pointer |
| cfg_count_i | input | CW | Number of transfers |
| cfg_size_i | input | 2 | Transfer size code |
| cfg_inc_rd_i | input | 1 | Advance the read pointer |
| cfg_inc_wr_i | input | 1 | Advance the write pointer |
| cfg_ring_bits_i | input | 5 | Ring width N, 0 = off |
| cfg_ring_wr_i | input | 1 | Ring applies to write (1) or read (0) pointer |
| cfg_bswap_i | input | 1 | Reverse byte order |
| cfg_paced_i | input | 1 | Wait for pace_req_i before each transfer |
| pace_req_i | input | 1 | Peripheral transfer request |
| clr_rd_err_i | input | 1 | Clear read error flag |
| clr_wr_err_i | input | 1 | Clear write error flag |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address / current read pointer |
| rd_size_o | output | 2 | Read size code |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_err_i | input | 1 | Read failed, valid with rd_ack_i |
| rd_data_i | input | 32 | Read data, right-aligned |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address / current write pointer |
| wr_size_o | output | 2 | Write size code |
| wr_data_o | output | 32 | Write data, right-aligned |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write failed, valid with wr_ack_i |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_rd_o | output | 1 | Sticky read error |
| err_wr_o | output | 1 | Sticky write error |
| err_any_o | output | 1 | OR of both error flags |
| remain_o | output | CW | Transfers left |

## Verification
Two functions can land on the same clock edge: a write acknowledged with an error, which sets the write flag, and a software clear of that same flag. The bench's bus responder raises clr_wr_err_i on exactly the cycle in which it returns wr_err_i, so both are sampled together. It then judges that err_wr_o and err_any_o stay 1 and that the channel has stopped with no done pulse. A plain clear on a later cycle must then bring the flag back to 0.

// File: rtl/dma_xfer_pkg.sv
// Shared types for the DMA transfer engine.
// Assumes a 32-bit data path and a 5-bit ring width field.
package dma_xfer_pkg;

    localparam int RING_W = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        xfer_size_e          size;
        logic                inc_rd;
        logic                inc_wr;
        logic [RING_W-1:0]   ring_bits;
        logic                ring_wr;
        logic                bswap;
    } chan_ctl_t;

endpackage

// File: rtl/dma_ptr_step.sv
// Next-address generator for one pointer.
// Adds the transfer size when incrementing is on. When the ring is on for
// this pointer, only the low ring_bits bits take the new value.
// Assumes ring_bits below AW when a ring is wanted; larger values wrap nothing.
module dma_ptr_step
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     ptr_i,
    input  xfer_size_e        size_i,
    input  logic              inc_i,
    input  logic              ring_en_i,
    input  logic [RING_W-1:0] ring_bits_i,
    output logic [AW-1:0]     next_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] step;
    logic [AW-1:0] sum;
    logic [AW-1:0] keep_mask;

    // Byte step for the selected transfer size (reserved code behaves as word).
    always_comb begin
        unique case (size_i)
            SZ_BYTE: step = AW'(1);
            SZ_HALF: step = AW'(2);
            default: step = AW'(4);
        endcase
        if (!inc_i) step = '0;
    end

    // Low bits allowed to change: all of them, unless the ring confines them.
    always_comb begin
        sum = ptr_i + step;
        if (ring_en_i && (ring_bits_i != '0))
            keep_mask = (ONE << ring_bits_i) - ONE;
        else
            keep_mask = '1;
        next_o = (ptr_i & ~keep_mask) | (sum & keep_mask);
    end

endmodule

// File: rtl/dma_lane_swap.sv
// Write-data former: zero-extends the read data to the transfer size and
// optionally reverses byte order inside a halfword or word.
// Assumes right-aligned data and DW a multiple of 32.
module dma_lane_swap
    import dma_xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data_i,
    input  xfer_size_e    size_i,
    input  logic          bswap_i,
    output logic [DW-1:0] data_o
);

    localparam int NB = 4;

    logic [31:0] word_rev;

    // Reverse the four bytes of the low word.
    for (genvar b = 0; b < NB; b++) begin : g_rev
        assign word_rev[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
    end

    // Select the lanes for the transfer size and apply the optional swap.
    always_comb begin
        data_o = '0;
        unique case (size_i)
            SZ_BYTE: data_o[7:0]  = data_i[7:0];
            SZ_HALF: data_o[15:0] = bswap_i ? {data_i[7:0], data_i[15:8]} : data_i[15:0];
            default: data_o[31:0] = bswap_i ? word_rev : data_i[31:0];
        endcase
    end

endmodule

// File: rtl/dma_seq_fsm.sv
// Transfer sequencer: start qualification, pacing wait, read phase, write
// phase and transfer counting. One transfer is in flight at a time.
// Assumes the bus holds ack for one cycle per request.
module dma_seq_fsm
    import dma_xfer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          enable_i,
    input  logic [CW-1:0] count_i,
    input  logic          paced_i,
    input  logic          pace_req_i,
    input  logic          rd_ack_i,
    input  logic          rd_err_i,
    input  logic          wr_ack_i,
    input  logic          wr_err_i,
    output logic          rd_req_o,
    output logic          wr_req_o,
    output logic          busy_o,
    output logic          load_o,
    output logic          capture_o,
    output logic          advance_o,
    output logic          done_o,
    output logic          rd_fault_o,
    output logic          wr_fault_o,
    output logic [CW-1:0] remain_o
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] remain_q;
    logic          paced_q;
    logic          done_q;
    logic          last_xfer;

    assign rd_req_o   = (state_q == ST_READ);
    assign wr_req_o   = (state_q == ST_WRITE);
    assign busy_o     = (state_q != ST_IDLE);
    assign load_o     = (state_q == ST_IDLE) && start_i && enable_i && (count_i != '0);
    assign capture_o  = rd_req_o && rd_ack_i && !rd_err_i;
    assign rd_fault_o = rd_req_o && rd_ack_i && rd_err_i;
    assign advance_o  = wr_req_o && wr_ack_i && !wr_err_i;
    assign wr_fault_o = wr_req_o && wr_ack_i && wr_err_i;
    assign last_xfer  = (remain_q == CW'(1));
    assign done_o     = done_q;
    assign remain_o   = remain_q;

    // Next-state selection for the read-then-write loop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_o) state_d = paced_i ? ST_WAIT : ST_READ;
            ST_WAIT:  if (pace_req_i) state_d = ST_READ;
            ST_READ:  if (rd_ack_i) state_d = rd_err_i ? ST_IDLE : ST_WRITE;
            ST_WRITE: begin
                if (wr_ack_i) begin
                    if (wr_err_i || last_xfer) state_d = ST_IDLE;
                    else                       state_d = paced_q ? ST_WAIT : ST_READ;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, remaining count, pacing mode and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            paced_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= advance_o && last_xfer;
            if (load_o) begin
                remain_q <= count_i;
                paced_q  <= paced_i;
            end else if (advance_o) begin
                remain_q <= remain_q - CW'(1);
            end
        end
    end

    // R9: never a read and a write request at once.
    p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    // R9: an unanswered read request stays up.
    p_read_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o);

    // R9: an unanswered write request stays up.
    p_write_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o);

    // R8: in paced mode a read follows a sampled request.
    p_paced_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) && paced_q |-> $past(pace_req_i));

    // R3: the done pulse comes with the channel idle.
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

    // R10: a bus fault ends the sequence without done.
    p_fault_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fault_o || wr_fault_o) |=> !busy_o && !done_o);

endmodule

// File: rtl/dma_xfer_engine.sv
// Single DMA channel top: pointer registers, control latch, data register
// and sticky error flags around the sequencer.
// Assumes a memory-style bus that answers each request with one ack cycle.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_enable_i,
    input  logic [AW-1:0]     cfg_rd_addr_i,
    input  logic [AW-1:0]     cfg_wr_addr_i,
    input  logic [CW-1:0]     cfg_count_i,
    input  logic [1:0]        cfg_size_i,
    input  logic              cfg_inc_rd_i,
    input  logic              cfg_inc_wr_i,
    input  logic [RING_W-1:0] cfg_ring_bits_i,
    input  logic              cfg_ring_wr_i,
    input  logic              cfg_bswap_i,
    input  logic              cfg_paced_i,
    input  logic              pace_req_i,
    input  logic              clr_rd_err_i,
    input  logic              clr_wr_err_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic [1:0]        rd_size_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic              wr_req_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [1:0]        wr_size_o,
    output logic [DW-1:0]     wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_rd_o,
    output logic              err_wr_o,
    output logic              err_any_o,
    output logic [CW-1:0]     remain_o
);

    chan_ctl_t     ctl_q;
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [AW-1:0] rd_ptr_nx, wr_ptr_nx;
    logic [DW-1:0] data_q, data_formed;
    logic          err_rd_q, err_wr_q;
    logic          load, capture, advance, rd_fault, wr_fault;

    dma_seq_fsm #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .enable_i   (cfg_enable_i),
        .count_i    (cfg_count_i),
        .paced_i    (cfg_paced_i),
        .pace_req_i (pace_req_i),
        .rd_ack_i   (rd_ack_i),
        .rd_err_i   (rd_err_i),
        .wr_ack_i   (wr_ack_i),
        .wr_err_i   (wr_err_i),
        .rd_req_o   (rd_req_o),
        .wr_req_o   (wr_req_o),
        .busy_o     (busy_o),
        .load_o     (load),
        .capture_o  (capture),
        .advance_o  (advance),
        .done_o     (done_o),
        .rd_fault_o (rd_fault),
        .wr_fault_o (wr_fault),
        .remain_o   (remain_o)
    );

    dma_ptr_step #(.AW(AW)) u_rd_step (
        .ptr_i       (rd_ptr_q),
        .size_i      (ctl_q.size),
        .inc_i       (ctl_q.inc_rd),
        .ring_en_i   (!ctl_q.ring_wr),
        .ring_bits_i (ctl_q.ring_bits),
        .next_o      (rd_ptr_nx)
    );

    dma_ptr_step #(.AW(AW)) u_wr_step (
        .ptr_i       (wr_ptr_q),
        .size_i      (ctl_q.size),
        .inc_i       (ctl_q.inc_wr),
        .ring_en_i   (ctl_q.ring_wr),
        .ring_bits_i (ctl_q.ring_bits),
        .next_o      (wr_ptr_nx)
    );

    dma_lane_swap #(.DW(DW)) u_swap (
        .data_i  (rd_data_i),
        .size_i  (ctl_q.size),
        .bswap_i (ctl_q.bswap),
        .data_o  (data_formed)
    );

    // Control latch: fields are frozen for the whole sequence at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{size: SZ_WORD, inc_rd: 1'b1, inc_wr: 1'b1,
                       ring_bits: '0, ring_wr: 1'b0, bswap: 1'b0};
        end else if (load) begin
            ctl_q <= '{size: xfer_size_e'(cfg_size_i), inc_rd: cfg_inc_rd_i,
                       inc_wr: cfg_inc_wr_i, ring_bits: cfg_ring_bits_i,
                       ring_wr: cfg_ring_wr_i, bswap: cfg_bswap_i};
        end
    end

    // Pointers: loaded at start, advanced only when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else if (load) begin
            rd_ptr_q <= cfg_rd_addr_i;
            wr_ptr_q <= cfg_wr_addr_i;
        end else if (advance) begin
            rd_ptr_q <= rd_ptr_nx;
            wr_ptr_q <= wr_ptr_nx;
        end
    end

    // Data holding register between the read and the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= data_formed;
    end

    // Sticky error flags; a fault in the clear cycle keeps the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_rd_q <= 1'b0;
            err_wr_q <= 1'b0;
        end else begin
            if (rd_fault)          err_rd_q <= 1'b1;
            else if (clr_rd_err_i) err_rd_q <= 1'b0;
            if (wr_fault)          err_wr_q <= 1'b1;
            else if (clr_wr_err_i) err_wr_q <= 1'b0;
        end
    end

    assign rd_addr_o = rd_ptr_q;
    assign wr_addr_o = wr_ptr_q;
    assign rd_size_o = ctl_q.size;
    assign wr_size_o = ctl_q.size;
    assign wr_data_o = data_q;
    assign err_rd_o  = err_rd_q;
    assign err_wr_o  = err_wr_q;
    assign err_any_o = err_rd_q | err_wr_q;

    // R9: address held while a read waits for its acknowledge.
    p_rd_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> $stable(rd_addr_o));

    // R9: address and data held while a write waits.
    p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> $stable(wr_addr_o) && $stable(wr_data_o));

    // R6: a ringed read pointer keeps its upper bits across an advance.
    p_ring_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !ctl_q.ring_wr && (ctl_q.ring_bits != '0)
        |=> ((rd_addr_o ^ $past(rd_addr_o)) >> $past(ctl_q.ring_bits)) == '0);

    // R11: an error flag only drops on a clear request.
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_wr_o && !clr_wr_err_i |=> err_wr_o);

    // R12: pointers move only at start or on an accepted write.
    p_ptr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !advance |=> $stable(rd_addr_o) && $stable(wr_addr_o));

endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, cfg_enable_i = 0;
    logic [31:0] cfg_rd_addr_i = 0, cfg_wr_addr_i = 0;
    logic [15:0] cfg_count_i = 0;
    logic [1:0]  cfg_size_i = 0;
    logic        cfg_inc_rd_i = 0, cfg_inc_wr_i = 0;
    logic [4:0]  cfg_ring_bits_i = 0;
    logic        cfg_ring_wr_i = 0, cfg_bswap_i = 0, cfg_paced_i = 0;
    logic        pace_req_i = 0, clr_rd_err_i = 0, clr_wr_err_i = 0;
    logic        rd_req_o, wr_req_o, rd_ack_i = 0, rd_err_i = 0, wr_ack_i = 0, wr_err_i = 0;
    logic [31:0] rd_addr_o, wr_addr_o, rd_data_i = 0, wr_data_o;
    logic [1:0]  rd_size_o, wr_size_o;
    logic        busy_o, done_o, err_rd_o, err_wr_o, err_any_o;
    logic [15:0] remain_o;

    dma_xfer_engine i_dma_xfer_engine (.*);

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    // bus responder controls and logs
    int lat_max = 0, pace_mode = 1, inj_rd = -1, inj_wr = -1;
    bit collide_clr = 0, clr_wr_req = 0;
    int n_rd = 0, n_wr = 0, n_done = 0, overlap = 0;
    logic [31:0] log_ra [64];
    logic [31:0] log_wa [64];
    logic [31:0] log_wd [64];
    logic [1:0]  log_sz [64];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] p, input int sz, input bit inc,
                                             input bit ring_here, input int n);
        logic [31:0] step, mask, s;
        step = !inc ? 0 : (sz == 0 ? 1 : (sz == 1 ? 2 : 4));
        mask = (ring_here && n != 0) ? ((32'd1 << n) - 1) : 32'hFFFF_FFFF;
        s = p + step;
        return (p & ~mask) | (s & mask);
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] d, input int sz, input bit bs);
        if (sz == 0) return {24'h0, d[7:0]};
        if (sz == 1) return bs ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
        return bs ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endfunction

    // Bus responder, pacing source and protocol monitor, all at the falling edge.
    initial begin
        int rw = 0, ww = 0;
        forever begin
            @(negedge clk);
            rd_ack_i = 0; rd_err_i = 0; wr_ack_i = 0; wr_err_i = 0;
            clr_wr_err_i = clr_wr_req;
            if (rd_req_o && wr_req_o) overlap++;
            if (done_o) n_done++;
            if (pace_mode == 1) pace_req_i = 1'($urandom % 2);
            if (rd_req_o) begin
                if (rw == 0) begin
                    rd_ack_i = 1;
                    rd_data_i = mem_rd(rd_addr_o);
                    rd_err_i = (n_rd == inj_rd);
                    if (n_rd < 64) begin log_ra[n_rd] = rd_addr_o; log_sz[n_rd] = rd_size_o; end
                    n_rd++;
                    rw = $urandom % (lat_max + 1);
                end else rw--;
            end
            if (wr_req_o) begin
                if (ww == 0) begin
                    wr_ack_i = 1;
                    wr_err_i = (n_wr == inj_wr);
                    if (wr_err_i && collide_clr) clr_wr_err_i = 1;
                    if (n_wr < 64) begin log_wa[n_wr] = wr_addr_o; log_wd[n_wr] = wr_data_o; end
                    n_wr++;
                    ww = $urandom % (lat_max + 1);
                end else ww--;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic issue(input int sz, input bit ir, input bit iw, input int rn, input bit rws,
                         input bit bs, input bit pc, input int cnt, input logic [31:0] ra,
                         input logic [31:0] wa, input bit en);
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_done = 0;
        cfg_size_i = 2'(sz); cfg_inc_rd_i = ir; cfg_inc_wr_i = iw; cfg_ring_bits_i = 5'(rn);
        cfg_ring_wr_i = rws; cfg_bswap_i = bs; cfg_paced_i = pc; cfg_count_i = 16'(cnt);
        cfg_rd_addr_i = ra; cfg_wr_addr_i = wa; cfg_enable_i = en; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy_o && t < 4000) begin @(negedge clk); t++; end
        chk(!busy_o, "R3 sequence end", 32'(busy_o), 0);
        @(negedge clk);
    endtask

    // Full sequence with an independent expected-value model.
    task automatic run_copy(input string req, input int sz, input bit ir, input bit iw,
                            input int rn, input bit rws, input bit bs, input bit pc,
                            input int cnt, input logic [31:0] ra, input logic [31:0] wa);
        logic [31:0] rp, wp;
        int bad = 0;
        issue(sz, ir, iw, rn, rws, bs, pc, cnt, ra, wa, 1);
        chk(busy_o == 1, "R2 busy after start", 32'(busy_o), 1);
        wait_idle();
        chk(n_rd == cnt && n_wr == cnt, {req, " R3 transfer count"}, 32'(n_wr), 32'(cnt));
        chk(n_done == 1, "R3 one done pulse", 32'(n_done), 1);
        rp = ra; wp = wa;
        for (int i = 0; i < cnt; i++) begin
            if (log_ra[i] !== rp) begin bad++; chk(0, {req, " R12 read address"}, log_ra[i], rp); end
            if (log_wa[i] !== wp) begin bad++; chk(0, {req, " R12 write address"}, log_wa[i], wp); end
            if (log_sz[i] !== 2'(sz)) begin bad++; chk(0, {req, " R4 size code"}, 32'(log_sz[i]), 32'(sz)); end
            if (log_wd[i] !== exp_data(mem_rd(rp), sz, bs)) begin
                bad++; chk(0, {req, " R7 write data"}, log_wd[i], exp_data(mem_rd(rp), sz, bs));
            end
            rp = exp_next(rp, sz, ir, !rws, rn);
            wp = exp_next(wp, sz, iw, rws, rn);
        end
        chk(bad == 0, {req, " per-transfer trace"}, 32'(bad), 0);
        chk(rd_addr_o == rp && wr_addr_o == wp, {req, " R12 final pointers"}, rd_addr_o, rp);
        chk(remain_o == 0, "R12 remain at end", 32'(remain_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !rd_req_o && !wr_req_o, "R1 idle after reset", 32'(busy_o), 0);
        chk(!err_rd_o && !err_wr_o && !err_any_o, "R1 flags clear", 32'(err_any_o), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // R3 R4 R12 word copy, both incrementing
        run_copy("R4 word", 2, 1, 1, 0, 0, 0, 0, 4, 32'h1000, 32'h2000);
        // R4 R7 byte with swap ignored, halfword and word swapped, reserved size
        run_copy("R7 byte", 0, 1, 1, 0, 0, 1, 0, 5, 32'h3001, 32'h4003);
        run_copy("R7 half swap", 1, 1, 1, 0, 0, 1, 0, 3, 32'h3002, 32'h4000);
        run_copy("R7 word swap", 2, 1, 1, 0, 0, 1, 0, 3, 32'h5000, 32'h6000);
        run_copy("R4 size three", 3, 1, 1, 0, 0, 0, 0, 2, 32'h5100, 32'h6100);
        // R5 fixed write pointer, fixed read pointer
        run_copy("R5 fixed write", 2, 1, 0, 0, 0, 0, 0, 4, 32'h7000, 32'hF000_0010);
        run_copy("R5 fixed read", 1, 0, 1, 0, 0, 0, 0, 4, 32'hF000_0020, 32'h7100);
        // R6 ring on read (8-byte ring) and on write (16-byte ring)
        run_copy("R6 read ring", 2, 1, 1, 3, 0, 0, 0, 6, 32'h1004, 32'h2000);
        run_copy("R6 write ring", 1, 1, 1, 4, 1, 0, 0, 10, 32'h3000, 32'h800C);

        // R2 disabled start and zero count are ignored
        issue(2, 1, 1, 0, 0, 0, 0, 4, 32'h100, 32'h200, 0);
        repeat (8) @(negedge clk);
        chk(!busy_o && n_rd == 0, "R2 disabled start ignored", 32'(n_rd), 0);
        issue(2, 1, 1, 0, 0, 0, 0, 0, 32'h100, 32'h200, 1);
        repeat (8) @(negedge clk);
        chk(!busy_o && n_rd == 0 && n_done == 0, "R2 zero count ignored", 32'(busy_o), 0);

        // R8 pacing: nothing without a request, one transfer per request pulse
        pace_mode = 0; pace_req_i = 0; lat_max = 0;
        issue(2, 1, 1, 0, 0, 0, 1, 3, 32'hA000, 32'hB000, 1);
        repeat (15) @(negedge clk);
        chk(busy_o && n_rd == 0, "R8 waits for request", 32'(n_rd), 0);
        pace_req_i = 1; @(negedge clk); pace_req_i = 0;
        repeat (10) @(negedge clk);
        chk(n_rd == 1 && n_wr == 1, "R8 one transfer per pulse", 32'(n_wr), 1);
        chk(remain_o == 2 && rd_addr_o == 32'hA004, "R12 pointer mid sequence", rd_addr_o, 32'hA004);
        pace_req_i = 1;
        wait_idle();
        chk(n_wr == 3, "R8 completes with request", 32'(n_wr), 3);
        pace_mode = 1;

        // R10 read error on second transfer
        inj_rd = 1;
        issue(2, 1, 1, 0, 0, 0, 0, 4, 32'hC000, 32'hD000, 1);
        wait_idle();
        inj_rd = -1;
        chk(err_rd_o && err_any_o && !err_wr_o, "R10 read error latched", 32'(err_rd_o), 1);
        chk(n_rd == 2 && n_wr == 1 && n_done == 0, "R10 stop without done", 32'(n_wr), 1);
        chk(rd_addr_o == 32'hC004, "R12 pointer at failed transfer", rd_addr_o, 32'hC004);
        // R11 plain clear
        clr_rd_err_i = 1; @(negedge clk); clr_rd_err_i = 0; @(negedge clk);
        chk(!err_rd_o && !err_any_o, "R11 clear read flag", 32'(err_rd_o), 0);

        // R11 write error in the same cycle as the clear
        inj_wr = 0; collide_clr = 1;
        issue(1, 1, 1, 0, 0, 0, 0, 3, 32'hE000, 32'hE800, 1);
        wait_idle();
        inj_wr = -1; collide_clr = 0;
        chk(err_wr_o && err_any_o, "R11 set beats clear", 32'(err_wr_o), 1);
        chk(n_done == 0 && n_wr == 1, "R10 write error stops", 32'(n_wr), 1);
        clr_wr_req = 1; @(negedge clk); @(negedge clk); clr_wr_req = 0; @(negedge clk);
        chk(!err_wr_o && !err_any_o, "R11 clear write flag", 32'(err_wr_o), 0);

        // Random sequences (R3 R4 R5 R6 R7 R8 R9 R12)
        void'($urandom(32'd1234));
        lat_max = 2;
        for (int k = 0; k < 30; k++) begin
            int sz = $urandom % 4;
            int rn = ($urandom % 3 == 0) ? 0 : 1 + $urandom % 6;
            run_copy("random", sz, 1'($urandom), 1'($urandom), rn, 1'($urandom), 1'($urandom),
                     1'($urandom), 1 + $urandom % 12, $urandom & 32'hFFFF_FFFC, $urandom);
        end
        chk(overlap == 0, "R9 read and write never together", 32'(overlap), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule